// File: doc/BRIEF.md
# Shift-Amount Register Funnel Shifter

This block is a 32-bit shift unit whose count lives in a small shift-amount register instead of coming with each shift. Setup operations load the amount register from the low bits of a source operand, from a byte-lane count scaled by eight, or from a 5-bit immediate. Each of these has a form for right shifts and a form for left shifts. Shift operations then read the register. They can extract 32 bits from a 64-bit operand pair (funnel), shift right logically or arithmetically, or shift left by the complement of the stored amount.

A left shift by n is done in two steps. First a setup loads the register with 32 − n. Then the left shift moves the operand by 32 minus the register value. The register is 6 bits wide and holds values up to 32 after setup. A direct special-register write can place any value from 0 to 63. The current amount is always visible on a read port, zero-extended to 32 bits. A setup takes effect for the very next issued shift, with no stall. Shift results appear one cycle after issue with a valid strobe.

Top module: `sar_shift_unit`

## Requirements
- R1: While reset is asserted and right after it, sar_rd is 0, res_valid is 0 and res_data is 0.
- R2: Opcode 0 (right setup) loads the amount register with src_s[4:0].
- R3: Opcode 1 (left setup) loads 32 − src_s[4:0], so a zero amount gives 32.
- R4: Opcode 2 (little-endian byte setup) loads (src_s × 8) mod 32. Opcode 3 (big-endian byte setup) loads 32 minus that value.
- R5: Opcode 4 (immediate setup) loads the register with imm5, where imm5[4] is the extra high bit and imm5[3:0] is the 4-bit field.
- R6: When sr_wr_en is high, the register takes sr_wr_data[5:0]. If a setup opcode is issued in the same cycle, the setup wins.
- R7: Opcode 5 (funnel) returns the low 32 bits of {src_s, src_t} shifted right by the amount.
- R8: Opcode 6 zero-extends src_t and opcode 7 sign-extends src_t, then each shifts right by the amount and keeps the low 32 bits. Any amount of 32 or more gives all zeros (opcode 6) or all copies of the sign bit (opcode 7).
- R9: Opcode 8 returns the low 32 bits of src_s shifted left by (32 − amount) mod 64. An amount of 32 returns src_s, and an amount of 0 or above 32 returns 0.
- R10: res_valid is high exactly one cycle after a shift opcode (5 to 8) is issued with op_valid. res_data holds its value otherwise. A register update becomes visible on sar_rd, and to a shift issued, in the next cycle.
- R11: Opcodes 9 to 15 change neither the amount register nor the result outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation select, encodings as in R2 to R11 |
| src_s | input | 32 | First source operand (upper half for funnel, left-shift operand, setup source) |
| src_t | input | 32 | Second source operand (lower half for funnel, right-shift operand) |
| imm5 | input | 5 | Immediate amount for opcode 4 |
| sr_wr_en | input | 1 | Direct write to the amount register |
| sr_wr_data | input | 32 | Write data, low 6 bits kept |
| sar_rd | output | 32 | Current amount, zero-extended |
| res_valid | output | 1 | Shift result strobe |
| res_data | output | 32 | Shift result |

## Verification
A corrupted amount register shows on sar_rd in the cycle after the bad update. It also shows on res_data one cycle after the next shift is issued. The bench compares both against its own model on every cycle, so such a fault cannot stay hidden behind later updates. The checks concentrate on the amount values where the paths part ways: 0, 32 and values above 32 written directly. At those values the left path, the sign fill and the funnel's use of the upper half are each visible at the ports in the cycle after the shift is issued.

// File: rtl/sar_shift_pkg.sv
package sar_shift_pkg;

  typedef enum logic [3:0] {
    OP_SET_RIGHT = 4'd0,
    OP_SET_LEFT  = 4'd1,
    OP_SET_BYTEL = 4'd2,
    OP_SET_BYTEB = 4'd3,
    OP_SET_IMM   = 4'd4,
    OP_FUNNEL    = 4'd5,
    OP_SRL       = 4'd6,
    OP_SRA       = 4'd7,
    OP_SLL       = 4'd8
  } shop_e;

  function automatic logic op_is_setup(input logic [3:0] op);
    return op <= 4'd4;
  endfunction

  function automatic logic op_is_shift(input logic [3:0] op);
    return (op >= 4'd5) && (op <= 4'd8);
  endfunction

endpackage

// File: rtl/sar_amount_reg.sv
module sar_amount_reg
  import sar_shift_pkg::*;
#(
  parameter int DW = 32,
  localparam int AMT_W = $clog2(DW),
  localparam int SAR_W = AMT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_en,
  input  logic [3:0]       op,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [AMT_W-1:0] imm_i,
  input  logic             wr_en,
  input  logic [SAR_W-1:0] wr_i,
  output logic [SAR_W-1:0] sar_q
);

  localparam logic [SAR_W-1:0] FULL = SAR_W'(DW);

  logic [AMT_W-1:0] byte_amt;
  logic [SAR_W-1:0] sar_d;
  logic             sar_en;

  assign byte_amt = {amt_i[AMT_W-4:0], 3'b000};

  always_comb begin
    sar_d  = sar_q;
    sar_en = 1'b0;
    if (setup_en) begin
      sar_en = 1'b1;
      unique case (op)
        OP_SET_RIGHT: sar_d = {1'b0, amt_i};
        OP_SET_LEFT:  sar_d = FULL - {1'b0, amt_i};
        OP_SET_BYTEL: sar_d = {1'b0, byte_amt};
        OP_SET_BYTEB: sar_d = FULL - {1'b0, byte_amt};
        default:      sar_d = {1'b0, imm_i};
      endcase
    end else if (wr_en) begin
      sar_en = 1'b1;
      sar_d  = wr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
    end else if (sar_en) begin
      sar_q <= sar_d;
    end
  end

  // R3: a left setup always leaves an amount in 1..DW
  a_r3_left_range: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_en && op == OP_SET_LEFT) |=> (sar_q != '0 && sar_q <= FULL));

  // R6: a direct write without a setup lands verbatim
  a_r6_wr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !setup_en) |=> (sar_q == $past(wr_i)));

  // R10: without an update the amount holds
  a_r10_sar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_en && !wr_en) |=> $stable(sar_q));

endmodule

// File: rtl/sar_funnel_core.sv
module sar_funnel_core
  import sar_shift_pkg::*;
#(
  parameter int DW = 32,
  localparam int AMT_W = $clog2(DW),
  localparam int SAR_W = AMT_W + 1
) (
  input  logic [3:0]       op,
  input  logic [DW-1:0]    src_s,
  input  logic [DW-1:0]    src_t,
  input  logic [SAR_W-1:0] sar,
  output logic [DW-1:0]    result
);

  localparam logic [SAR_W-1:0] FULL = SAR_W'(DW);

  logic signed [2*DW:0] wide;
  logic signed [2*DW:0] shifted;
  logic                 left_over;

  always_comb begin
    unique case (op)
      OP_SRL:  wide = {1'b0, {DW{1'b0}}, src_t};
      OP_SRA:  wide = {src_t[DW-1], {DW{src_t[DW-1]}}, src_t};
      OP_SLL:  wide = {1'b0, src_s, {DW{1'b0}}};
      default: wide = {1'b0, src_s, src_t};
    endcase
  end

  assign shifted   = wide >>> sar;
  assign left_over = (op == OP_SLL) && (sar > FULL);
  assign result    = left_over ? '0 : shifted[DW-1:0];

endmodule

// File: rtl/sar_shift_unit.sv
module sar_shift_unit
  import sar_shift_pkg::*;
#(
  parameter int DW = 32,
  localparam int AMT_W = $clog2(DW),
  localparam int SAR_W = AMT_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_code,
  input  logic [DW-1:0]   src_s,
  input  logic [DW-1:0]   src_t,
  input  logic [AMT_W-1:0] imm5,
  input  logic            sr_wr_en,
  input  logic [DW-1:0]   sr_wr_data,
  output logic [DW-1:0]   sar_rd,
  output logic            res_valid,
  output logic [DW-1:0]   res_data
);

  logic             setup_fire;
  logic             shift_fire;
  logic [SAR_W-1:0] sar_q;
  logic [DW-1:0]    core_res;
  logic             valid_d;
  logic [DW-1:0]    res_d;
  logic             unused_hi;

  assign unused_hi  = ^{sr_wr_data[DW-1:SAR_W]};
  assign setup_fire = op_valid && op_is_setup(op_code);
  assign shift_fire = op_valid && op_is_shift(op_code);

  sar_amount_reg #(.DW(DW)) amt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .setup_en (setup_fire),
    .op       (op_code),
    .amt_i    (src_s[AMT_W-1:0]),
    .imm_i    (imm5),
    .wr_en    (sr_wr_en),
    .wr_i     (sr_wr_data[SAR_W-1:0]),
    .sar_q    (sar_q)
  );

  sar_funnel_core #(.DW(DW)) core_i (
    .op     (op_code),
    .src_s  (src_s),
    .src_t  (src_t),
    .sar    (sar_q),
    .result (core_res)
  );

  always_comb begin
    valid_d = shift_fire;
    res_d   = shift_fire ? core_res : res_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= valid_d;
      res_data  <= res_d;
    end
  end

  assign sar_rd = {{(DW-SAR_W){1'b0}}, sar_q};

  // R10: strobe follows a shift issue by one cycle
  a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(shift_fire));

  // R2: right setup lands on the read port next cycle
  a_r2_right_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_fire && op_code == OP_SET_RIGHT) |=>
    (sar_rd == DW'($past(src_s[AMT_W-1:0]))));

  // R8: arithmetic shift by a full word or more saturates to the sign
  a_r8_sra_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && op_code == OP_SRA && sar_rd >= DW) |=>
    (res_data == {DW{$past(src_t[DW-1])}}));

  // R9: left shift with a zero amount clears the result
  a_r9_sll_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && op_code == OP_SLL && sar_rd == '0) |=> (res_data == '0));

  // R11: unused opcodes leave everything alone
  a_r11_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 4'd8 && !sr_wr_en) |=>
    ($stable(sar_rd) && $stable(res_data) && !res_valid));

endmodule

// File: tb/sar_shift_unit_tb.sv
module sar_shift_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [31:0] src_s, src_t;
  logic [4:0]  imm5;
  logic        sr_wr_en;
  logic [31:0] sr_wr_data;
  logic [31:0] sar_rd;
  logic        res_valid;
  logic [31:0] res_data;

  int vectors = 0;
  int errors  = 0;

  logic [5:0]  m_sar;
  logic [31:0] m_res;

  always #10 clk = ~clk;

  sar_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_s(src_s), .src_t(src_t), .imm5(imm5), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .sar_rd(sar_rd), .res_valid(res_valid),
    .res_data(res_data)
  );

  function automatic logic [31:0] ref_shift(input logic [3:0] op,
      input logic [31:0] s, input logic [31:0] t, input logic [5:0] a);
    logic [63:0] x;
    case (op)
      4'd5: x = {s, t} >> a;
      4'd6: x = {32'h0, t} >> a;
      4'd7: x = $signed({{32{t[31]}}, t}) >>> a;
      default: x = {32'h0, s} << ((6'd32 - a) & 6'h3f);
    endcase
    return x[31:0];
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic wr);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      default: return wr ? "R6" : "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [31:0] s,
                      input logic [31:0] t, input logic [4:0] im,
                      input logic wr, input logic [31:0] wd);
    logic shift_op;
    string tg;
    op_valid = v; op_code = op; src_s = s; src_t = t; imm5 = im;
    sr_wr_en = wr; sr_wr_data = wd;
    shift_op = v && op >= 4'd5 && op <= 4'd8;
    tg = v ? tag_of(op, wr) : (wr ? "R6" : "R10");
    if (shift_op) m_res = ref_shift(op, s, t, m_sar);
    if (v && op <= 4'd4) begin
      case (op)
        4'd0: m_sar = {1'b0, s[4:0]};
        4'd1: m_sar = 6'd32 - {1'b0, s[4:0]};
        4'd2: m_sar = {1'b0, s[1:0], 3'b000};
        4'd3: m_sar = 6'd32 - {1'b0, s[1:0], 3'b000};
        default: m_sar = {1'b0, im};
      endcase
    end else if (wr) begin
      m_sar = wd[5:0];
    end
    @(posedge clk);
    @(negedge clk);
    check(sar_rd == {26'h0, m_sar}, tg, sar_rd, {26'h0, m_sar});
    check(res_valid == shift_op, "R10", {31'h0, res_valid}, {31'h0, shift_op});
    check(res_data == m_res, tg, res_data, m_res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    rst_n = 1'b0; op_valid = 0; op_code = 0; src_s = 0; src_t = 0;
    imm5 = 0; sr_wr_en = 0; sr_wr_data = 0;
    m_sar = 0; m_res = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sar_rd == 0, "R1", sar_rd, 0);
    check(res_valid == 0, "R1", {31'h0, res_valid}, 0);
    check(res_data == 0, "R1", res_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sar_rd == 0 && res_valid == 0, "R1", sar_rd, 0);

    // directed corners
    step(1, 4'd1, 32'h0, 0, 0, 0, 0);                   // R3 amount 0 -> 32
    step(1, 4'd8, 32'hdead_beef, 0, 0, 0, 0);           // R9 returns s
    step(1, 4'd7, 0, 32'h8000_1234, 0, 0, 0);           // R8 saturate sign
    step(1, 4'd6, 0, 32'hffff_ffff, 0, 0, 0);           // R8 zeros
    step(1, 4'd5, 32'h1234_5678, 32'h9abc_def0, 0, 0, 0); // R7 returns s
    step(1, 4'd0, 32'hffff_ffe0, 0, 0, 0, 0);           // R2 zero amount
    step(1, 4'd8, 32'hffff_ffff, 0, 0, 0, 0);           // R9 zero
    step(0, 4'd0, 0, 0, 0, 1, 32'hffff_ff3f);           // R6 write 63
    step(1, 4'd8, 32'hffff_ffff, 0, 0, 0, 0);           // R9 above 32
    step(1, 4'd5, 32'h8000_0000, 32'h1, 0, 0, 0);       // R7 s>>31
    step(1, 4'd7, 0, 32'h7fff_ffff, 0, 0, 0);           // R8 positive
    step(1, 4'd3, 32'h4, 0, 0, 0, 0);                   // R4 BE -> 32
    step(1, 4'd2, 32'h7, 0, 0, 0, 0);                   // R4 LE -> 24
    step(1, 4'd4, 0, 0, 5'h13, 1, 32'h5);               // R5 and R6 priority
    step(1, 4'd12, 32'h1f, 32'h1, 0, 0, 0);             // R11 no effect
    step(1, 4'd6, 0, 32'hf000_0000, 0, 0, 0);           // R8 by 19
    step(0, 4'd6, 32'h1, 32'h1, 0, 0, 0);               // R10 hold

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rs, rt;
      rs = $urandom;
      rt = $urandom;
      if ($urandom_range(0, 3) == 0) rs = rs & 32'h3f;
      step($urandom_range(0, 9) != 0, 4'($urandom_range(0, 15)), rs, rt,
           5'($urandom), $urandom_range(0, 9) == 0, $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule